// File: doc/BRIEF.md
# Interrupt Acknowledge Unit with Per-Source Software Interrupts

This block serves the acknowledge read of one CPU's interface on an interrupt controller. It holds that CPU's view of interrupt state: a pending latch for every hardware interrupt, an active bit for every interrupt, and a bitmap of requesting source CPUs for each software-generated interrupt (SGI). When the CPU strobes an acknowledge, the block picks the best pending and enabled interrupt and marks it active. It then retires its pending state and returns a 32-bit ID word.

SGIs keep one pending bit per source CPU. An acknowledge retires only the lowest-numbered source and reports that source in the ID word. The SGI stays pending while any other source remains. A legacy mode treats SGIs like any other interrupt. Pending requests arrive as one-cycle pulses (`set_pend` for hardware IDs, `sgi_post` for SGIs). A level-triggered line adds to the pending state while it is asserted.

Each strobe is classified in one cycle into one of five outcomes, kept in the enumerated register `kind_q`. AK_IDLE means no strobe. AK_SPURIOUS means nothing is eligible. AK_HIDDEN means the winner is in a group the requester may not take. AK_SGI means a source-tracked grant. AK_PERIPH means a plain grant, which is also used for every ID in legacy mode. The step taken in each cycle is IDLE→outcome: the outcome register loads on every clock and falls back to AK_IDLE when no strobe is present.

Top module: `ack_unit`

## Requirements
- R1: After reset, `ack_data` is 0 and no interrupt is pending or active. Every SGI source bitmap is empty.
- R2: An acknowledge with no interrupt both pending and enabled returns 1023 and changes no pending, active or source state. A disabled interrupt is never chosen.
- R3: The winner is the pending, enabled ID with the numerically lowest priority value. Among equal priority values, the lowest ID wins.
- R4: If `ack_grp_ok[irq_group[winner]]` is 0, the acknowledge returns 1022 and changes no state.
- R5: A granted acknowledge sets the active bit of exactly the granted ID. Active bits change only on the cycle after a strobe.
- R6: For an SGI (ID < 16) outside legacy mode, only the lowest set bit of its source bitmap is cleared. The word carries the ID in bits 9:0 and that source number in bits 12:10.
- R7: An SGI reads as pending exactly while its source bitmap is nonzero. Its pending state clears only when the last source is retired.
- R8: For IDs 16 to 95, a grant clears the pending latch and returns the bare ID, with bits 12:10 at 0.
- R9: With `legacy_mode` at 1, any granted ID returns the bare ID. A granted SGI has its whole source bitmap cleared.
- R10: A level-triggered ID (`irq_level` 1) whose `irq_line` is high still reads as pending after it is granted. It stops being pending when the line drops.
- R11: A post or `set_pend` for the granted ID in the same cycle as its acknowledge takes effect after the clear. This holds even for the very source bit being retired.
- R12: `ack_data` bits 31:13 are always 0. `ack_data` and all state update on the clock edge that samples the strobe, and `ack_data` holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Acknowledge strobe, one cycle per read |
| legacy_mode | input | 1 | 1: no source tracking, bare IDs for all interrupts |
| ack_grp_ok | input | 2 | Bit g set: requester may acknowledge group g |
| irq_enable | input | 96 | Per-ID enable |
| irq_group | input | 96 | Per-ID group number (0 or 1) |
| irq_level | input | 96 | Per-ID level-triggered flag (ignored below ID 16) |
| irq_line | input | 96 | Per-ID input line level |
| irq_prio | input | 768 | Priority of ID i in bits [8i+7:8i], lower value wins |
| set_pend | input | 96 | Pulse sets pending latch of ID i (ignored below ID 16) |
| sgi_post | input | 1 | Pulse posting an SGI from one source |
| sgi_post_id | input | 4 | SGI number being posted |
| sgi_post_src | input | 3 | Source CPU of the posted SGI |
| ack_data | output | 32 | Returned ID word |
| pend_o | output | 96 | Effective pending state per ID |
| active_o | output | 96 | Active state per ID |
| sgi_src_o | output | 128 | Source bitmap of SGI s in bits [8s+7:8s] |

## Verification
Two functions can fall in the same cycle: an acknowledge retiring an interrupt, and a new post or pending pulse for that same interrupt. The bench provokes this by raising `sgi_post` or `set_pend` on the cycle of the strobe. It does so both for the SGI source bit being retired and for a different source bit, and also for a hardware ID. The bench judges the result on the following cycle, against the rule that the new request is applied after the clear: the re-posted bit is still set, the SGI remains pending, and the hardware latch stays set.

// File: rtl/ack_pkg.sv
package ack_pkg;
    typedef enum logic [2:0] {
        AK_IDLE,
        AK_SPURIOUS,
        AK_HIDDEN,
        AK_SGI,
        AK_PERIPH
    } ack_kind_e;

    localparam int unsigned ID_W      = 10;
    localparam logic [ID_W-1:0] ID_NONE   = 10'd1023;
    localparam logic [ID_W-1:0] ID_HIDDEN = 10'd1022;
endpackage

// File: rtl/ack_select.sv
module ack_select #(
    parameter int NUM_IRQ = 96,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [IDX_W-1:0]          best_idx
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_p   = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best_p)) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_p   = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/ack_srcpick.sv
module ack_srcpick #(
    parameter int NUM_CPU = 8,
    localparam int SRC_W  = $clog2(NUM_CPU)
) (
    input  logic [NUM_CPU-1:0] bits,
    output logic [SRC_W-1:0]   idx,
    output logic [NUM_CPU-1:0] lowest
);
    always_comb begin
        idx    = '0;
        lowest = '0;
        for (int i = NUM_CPU - 1; i >= 0; i--) begin
            if (bits[i]) begin
                idx    = SRC_W'(i);
                lowest = NUM_CPU'(1) << i;
            end
        end
    end
endmodule

// File: rtl/ack_state.sv
module ack_state #(
    parameter int NUM_IRQ = 96,
    parameter int NUM_SGI = 16,
    parameter int NUM_CPU = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int SGI_W  = $clog2(NUM_SGI),
    localparam int SRC_W  = $clog2(NUM_CPU)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic [IDX_W-1:0]           take_idx,
    input  logic [NUM_CPU-1:0]         sgi_clr_mask,
    input  logic [NUM_IRQ-1:0]         set_pend,
    input  logic                       sgi_post,
    input  logic [SGI_W-1:0]           sgi_post_id,
    input  logic [SRC_W-1:0]           sgi_post_src,
    input  logic [NUM_IRQ-1:0]         irq_level,
    input  logic [NUM_IRQ-1:0]         irq_line,
    output logic [NUM_IRQ-1:0]         pend_eff,
    output logic [NUM_IRQ-1:0]         active,
    output logic [NUM_SGI*NUM_CPU-1:0] sgi_bits
);
    localparam logic [NUM_IRQ-1:0] HW_MASK = ~((NUM_IRQ'(1) << NUM_SGI) - NUM_IRQ'(1));

    logic [NUM_IRQ-1:0] latch_q;
    logic [NUM_IRQ-1:0] take_vec;
    logic [NUM_CPU-1:0] bm_q [NUM_SGI];

    assign take_vec = take ? (NUM_IRQ'(1) << take_idx) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            active  <= '0;
        end else begin
            latch_q <= ((latch_q & ~take_vec) | set_pend) & HW_MASK;
            active  <= active | take_vec;
        end
    end

    for (genvar g = 0; g < NUM_SGI; g++) begin : g_sgi
        logic [NUM_CPU-1:0] clr_g;
        logic [NUM_CPU-1:0] set_g;
        assign clr_g = (take && take_idx == IDX_W'(g)) ? sgi_clr_mask : '0;
        assign set_g = (sgi_post && sgi_post_id == SGI_W'(g)) ? (NUM_CPU'(1) << sgi_post_src) : '0;
        always_ff @(posedge clk) begin
            if (!rst_n) bm_q[g] <= '0;
            else        bm_q[g] <= (bm_q[g] & ~clr_g) | set_g;
        end
        assign sgi_bits[g*NUM_CPU +: NUM_CPU] = bm_q[g];
        assign pend_eff[g] = |bm_q[g];
    end

    for (genvar i = NUM_SGI; i < NUM_IRQ; i++) begin : g_hw
        assign pend_eff[i] = latch_q[i] | (irq_level[i] & irq_line[i]);
    end
endmodule

// File: rtl/ack_unit.sv
module ack_unit
    import ack_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int NUM_SGI = 16,
    parameter int NUM_CPU = 8,
    parameter int PRIO_W  = 8,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int SGI_W  = $clog2(NUM_SGI),
    localparam int SRC_W  = $clog2(NUM_CPU)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ack_req,
    input  logic                       legacy_mode,
    input  logic [1:0]                 ack_grp_ok,
    input  logic [NUM_IRQ-1:0]         irq_enable,
    input  logic [NUM_IRQ-1:0]         irq_group,
    input  logic [NUM_IRQ-1:0]         irq_level,
    input  logic [NUM_IRQ-1:0]         irq_line,
    input  logic [NUM_IRQ*PRIO_W-1:0]  irq_prio,
    input  logic [NUM_IRQ-1:0]         set_pend,
    input  logic                       sgi_post,
    input  logic [SGI_W-1:0]           sgi_post_id,
    input  logic [SRC_W-1:0]           sgi_post_src,
    output logic [DATA_W-1:0]          ack_data,
    output logic [NUM_IRQ-1:0]         pend_o,
    output logic [NUM_IRQ-1:0]         active_o,
    output logic [NUM_SGI*NUM_CPU-1:0] sgi_src_o
);
    logic               found;
    logic [IDX_W-1:0]   sel_idx;
    logic               sel_is_sgi;
    logic [NUM_CPU-1:0] sel_bm;
    logic [SRC_W-1:0]   src_idx;
    logic [NUM_CPU-1:0] src_low;
    ack_kind_e          kind_d, kind_q;
    logic [DATA_W-1:0]  data_d;
    logic               take;
    logic [NUM_CPU-1:0] clr_mask;

    ack_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_sel (
        .cand(pend_o & irq_enable), .prio_flat(irq_prio),
        .found(found), .best_idx(sel_idx)
    );

    assign sel_is_sgi = (int'(sel_idx) < NUM_SGI);
    assign sel_bm     = sel_is_sgi ? sgi_src_o[SGI_W'(sel_idx)*NUM_CPU +: NUM_CPU] : '0;

    ack_srcpick #(.NUM_CPU(NUM_CPU)) u_src (
        .bits(sel_bm), .idx(src_idx), .lowest(src_low)
    );

    // outcome decode
    always_comb begin
        if (!ack_req)                           kind_d = AK_IDLE;
        else if (!found)                        kind_d = AK_SPURIOUS;
        else if (!ack_grp_ok[irq_group[sel_idx]]) kind_d = AK_HIDDEN;
        else if (sel_is_sgi && !legacy_mode)    kind_d = AK_SGI;
        else                                    kind_d = AK_PERIPH;
    end

    // outcome actions
    always_comb begin
        data_d   = ack_data;
        take     = 1'b0;
        clr_mask = '0;
        unique case (kind_d)
            AK_IDLE:     data_d = ack_data;
            AK_SPURIOUS: data_d = DATA_W'(ID_NONE);
            AK_HIDDEN:   data_d = DATA_W'(ID_HIDDEN);
            AK_SGI: begin
                data_d   = DATA_W'({src_idx, ID_W'(sel_idx)});
                take     = 1'b1;
                clr_mask = src_low;
            end
            AK_PERIPH: begin
                data_d   = DATA_W'(ID_W'(sel_idx));
                take     = 1'b1;
                clr_mask = '1;
            end
            default: data_d = ack_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= AK_IDLE;
            ack_data <= '0;
        end else begin
            kind_q   <= kind_d;
            ack_data <= data_d;
        end
    end

    ack_state #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI), .NUM_CPU(NUM_CPU)) u_state (
        .clk(clk), .rst_n(rst_n), .take(take), .take_idx(sel_idx),
        .sgi_clr_mask(clr_mask), .set_pend(set_pend), .sgi_post(sgi_post),
        .sgi_post_id(sgi_post_id), .sgi_post_src(sgi_post_src),
        .irq_level(irq_level), .irq_line(irq_line),
        .pend_eff(pend_o), .active(active_o), .sgi_bits(sgi_src_o)
    );

    // R12
    hi_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_data[DATA_W-1:ID_W+SRC_W] == '0);
    // R12
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack_req) |-> $stable(ack_data));
    // R2 R4
    reject_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == AK_SPURIOUS || kind_q == AK_HIDDEN) |-> active_o == $past(active_o));
    // R5
    one_new_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_o & ~$past(active_o)));
    // R5
    active_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(active_o & ~$past(active_o))) |-> $past(ack_req));
    // R8
    bare_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind_q == AK_PERIPH |-> ack_data[ID_W+SRC_W-1:ID_W] == '0);
    // R6
    one_src_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind_q == AK_SGI |-> $countones($past(sgi_src_o) & ~sgi_src_o) <= 1);
endmodule

// File: tb/tb_ack_unit.sv
module tb_ack_unit;
    localparam int N = 96;
    localparam int S = 16;

    logic clk = 0;
    always #5 clk = ~clk;

    logic rst_n, ack_req, legacy_mode, sgi_post;
    logic [1:0] ack_grp_ok;
    logic [N-1:0] irq_enable, irq_group, irq_level, irq_line, set_pend;
    logic [N*8-1:0] irq_prio;
    logic [3:0] sgi_post_id;
    logic [2:0] sgi_post_src;
    logic [31:0] ack_data;
    logic [N-1:0] pend_o, active_o;
    logic [S*8-1:0] sgi_src_o;

    logic [7:0] pr [N];
    always_comb for (int i = 0; i < N; i++) irq_prio[i*8 +: 8] = pr[i];

    ack_unit dut (.*);

    // bench model
    logic [7:0] mb [S];
    logic [N-1:0] mpl, mact;
    int n_chk = 0, n_bad = 0;

    function automatic logic eff(int i);
        if (i < S) return |mb[i];
        return mpl[i] | (irq_level[i] & irq_line[i]);
    endfunction

    function automatic logic [N-1:0] pend_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = eff(i);
        return v;
    endfunction

    function automatic logic [S*8-1:0] bm_vec();
        logic [S*8-1:0] v;
        for (int g = 0; g < S; g++) v[g*8 +: 8] = mb[g];
        return v;
    endfunction

    function automatic logic [31:0] expect_word(logic leg, logic [1:0] gok);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (irq_enable[i] && eff(i) && (best < 0 || pr[i] < pr[best])) best = i;
        if (best < 0) return 32'd1023;
        if (!gok[irq_group[best]]) return 32'd1022;
        if (best < S && !leg) begin
            for (int b = 0; b < 8; b++)
                if (mb[best][b]) return 32'(best) | (32'(b) << 10);
        end
        return 32'(best);
    endfunction

    task automatic chk(logic ok, string req, logic [N*2-1:0] act, logic [N*2-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        chk(pend_o === pend_vec(), {req, " pending"}, N*2'(pend_o), N*2'(pend_vec()));
        chk(active_o === mact, "R5 active", N*2'(active_o), N*2'(mact));
        chk(sgi_src_o === bm_vec(), {req, " sources"}, N*2'(sgi_src_o), N*2'(bm_vec()));
    endtask

    task automatic post(int id, int src);
        @(negedge clk);
        sgi_post = 1; sgi_post_id = 4'(id); sgi_post_src = 3'(src);
        @(negedge clk);
        sgi_post = 0;
        mb[id][src] = 1'b1;
    endtask

    task automatic raise(int id);
        @(negedge clk);
        set_pend = '0; set_pend[id] = 1'b1;
        @(negedge clk);
        set_pend = '0;
        mpl[id] = 1'b1;
    endtask

    // acknowledge, optionally with a simultaneous SGI post (pid>=0) or hardware raise (hid>=0)
    task automatic ack(string req, logic leg = 0, logic [1:0] gok = 2'b11,
                       int pid = -1, int psrc = 0, int hid = -1);
        logic [31:0] w;
        int id;
        w = expect_word(leg, gok);
        @(negedge clk);
        ack_req = 1; legacy_mode = leg; ack_grp_ok = gok;
        if (pid >= 0) begin sgi_post = 1; sgi_post_id = 4'(pid); sgi_post_src = 3'(psrc); end
        if (hid >= 0) set_pend[hid] = 1'b1;
        @(negedge clk);
        ack_req = 0; sgi_post = 0; set_pend = '0; legacy_mode = 0;
        if (w[9:0] < 10'd1022) begin
            id = int'(w[9:0]);
            mact[id] = 1'b1;
            if (id < S) begin
                if (leg) mb[id] = '0;
                else     mb[id][w[12:10]] = 1'b0;
            end else mpl[id] = 1'b0;
        end
        if (pid >= 0) mb[pid][psrc] = 1'b1;
        if (hid >= 0) mpl[hid] = 1'b1;
        chk(ack_data === w, {req, " data"}, N*2'(ack_data), N*2'(w));
        check_state(req);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; ack_req = 0; legacy_mode = 0; sgi_post = 0; ack_grp_ok = 2'b11;
        sgi_post_id = 0; sgi_post_src = 0; set_pend = '0;
        irq_enable = '1; irq_group = '0; irq_level = '0; irq_line = '0;
        for (int i = 0; i < N; i++) pr[i] = 8'(((i * 11) % 17) * 4);
        for (int g = 0; g < S; g++) mb[g] = '0;
        mpl = '0; mact = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(ack_data === 32'd0, "R1 data", N*2'(ack_data), 0);
        check_state("R1");

        // R2 empty acknowledge
        ack("R2 empty");

        // R6 R7 every SGI with a computed source pattern
        for (int g = 0; g < S; g++) begin
            int m = ((g * 53 + 29) % 255) + 1;
            for (int b = 7; b >= 0; b--) if (m[b]) post(g, b);
            for (int k = 0; k < 9; k++) ack("R6 R7 sgi drain");
        end

        // R3 R8 hardware priority sweep with ties
        for (int r = 0; r < 6; r++) begin
            for (int j = 0; j < 6; j++) raise(16 + ((r * 31 + j * 17) % 80));
            for (int k = 0; k < 7; k++) ack("R3 R8 arbitration");
        end

        // R3 mixed SGI and hardware, equal priorities tie to lowest ID
        pr[5] = 8'd20; pr[40] = 8'd20; pr[30] = 8'd20;
        raise(40); raise(30); post(5, 6);
        for (int k = 0; k < 4; k++) ack("R3 tie");

        // R2 disabled interrupt is never chosen
        irq_enable[50] = 1'b0;
        raise(50);
        ack("R2 disabled");
        irq_enable[50] = 1'b1;
        ack("R2 enabled again");

        // R4 hidden group
        pr[60] = 8'd0; irq_group[60] = 1'b1;
        raise(60);
        ack("R4 hidden", 1'b0, 2'b01);
        ack("R4 allowed", 1'b0, 2'b11);

        // R10 level line keeps pending
        irq_level[70] = 1'b1; irq_line[70] = 1'b1;
        @(negedge clk);
        ack("R10 level grant");
        irq_line[70] = 1'b0;
        @(negedge clk);
        check_state("R10 line dropped");

        // R9 legacy mode
        post(3, 2); post(3, 5);
        ack("R9 legacy sgi", 1'b1);
        raise(20);
        ack("R9 legacy hw", 1'b1);

        // R11 same-cycle post and acknowledge
        post(7, 1);
        ack("R11 same src", 1'b0, 2'b11, 7, 1);
        ack("R11 other src", 1'b0, 2'b11, 7, 4);
        ack("R11 drain");
        raise(33);
        ack("R11 hw raise", 1'b0, 2'b11, -1, 0, 33);
        ack("R11 hw drain");

        // R12 data holds without a strobe
        post(9, 3);
        ack("R12 load");
        repeat (3) @(negedge clk);
        chk(ack_data === 32'(9 | (3 << 10)), "R12 hold", N*2'(ack_data), N*2'(9 | (3 << 10)));
        ack("R2 final empty");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule